// File: doc/BRIEF.md
# Write-Locked Real-Time Clock Source Selector

This block chooses the clock that drives a real-time counter. There are three candidate sources: a low-speed crystal clock, a low-speed internal RC clock, and the high-speed crystal clock divided by 128. Software writes a two-bit source field. The write is accepted only while the protection-release input is high. The first write of a non-zero value then freezes the field until the next backup-domain reset.

The block contains the divide-by-128 prescaler, which runs from the high-speed clock. It also produces a validity flag. Of the three sources, only the low-speed crystal lives in the battery-backed domain. When the main supply is flagged off, the other two sources stop, so the flag drops whenever either of them is selected.

Top module: `rtcsel_top`

## Requirements
- R1: The source field is encoded as 01 = low-speed crystal (`lse_clk`), 10 = low-speed RC (`lsi_clk`) and 11 = high-speed clock divided by 128. While a source is selected, `rtc_clk` follows it.
- R2: When `bkp_rst` is high at a rising edge of `clk`, `sel_q` reads 00 after that edge.
- R3: The first accepted write of a non-zero value locks the field. Every later write leaves `sel_q` unchanged until `bkp_rst`.
- R4: A write made while `wr_unprot` is 0 leaves `sel_q` unchanged.
- R5: The divided clock is low for the first 64 `hse_clk` cycles after `hse_rst` and then alternates 64 cycles high and 64 cycles low.
- R6: While `sel_q` is 00, `rtc_clk` and `clk_valid` are both low.
- R7: `clk_valid` is low when `main_pwr_off` is 1 and the selected source is not 01. It is high for any non-zero selection otherwise.
- R8: An accepted write of 00 does not lock the field: a later non-zero write is still accepted.
- R9: An accepted write appears on `sel_q` right after the `clk` edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| bkp_rst | input | 1 | Synchronous active-high backup-domain reset |
| wr_en | input | 1 | Write strobe for the source field |
| wr_sel | input | 2 | Source value to be written |
| wr_unprot | input | 1 | Write-protection release; writes are accepted only while high |
| hse_clk | input | 1 | High-speed crystal clock |
| hse_rst | input | 1 | Synchronous active-high reset of the prescaler |
| lse_clk | input | 1 | Low-speed crystal clock |
| lsi_clk | input | 1 | Low-speed RC clock |
| main_pwr_off | input | 1 | High when the main supply is off |
| sel_q | output | 2 | Current source field |
| rtc_clk | output | 1 | Selected real-time clock |
| clk_valid | output | 1 | High when the selected source keeps running in the current power state |

## Verification
The assertions assume three things about the inputs:
- `bkp_rst` is high at the first `clk` edge.
- The write inputs are stable around each `clk` edge.
- The low-speed clocks, which are sampled only by the output path, change on `clk` edges and never in the middle of a cycle.

The bench meets these assumptions. It drives writes on falling edges and toggles the low-speed clocks from counters on rising edges. It ties `hse_clk` to `clk`, so the prescaler phase can be predicted exactly.

// File: rtl/rtcsel_pkg.sv
package rtcsel_pkg;

    localparam int SEL_W      = 2;
    localparam int PRESC_DIV  = 128;
    localparam int NUM_SRC    = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SRC_NONE = 2'b00,
        SRC_XTAL = 2'b01,
        SRC_RC   = 2'b10,
        SRC_HDIV = 2'b11
    } rtc_src_e;

    typedef struct packed {
        logic     en;
        logic     unprot;
        rtc_src_e sel;
    } wr_req_t;

    typedef struct packed {
        logic     run;
        logic     valid;
    } clk_out_t;

    function automatic logic survives_main_loss(rtc_src_e s);
        return s == SRC_XTAL;
    endfunction

    function automatic logic write_accepted(wr_req_t r, rtc_src_e cur);
        return r.en && r.unprot && (cur == SRC_NONE);
    endfunction

endpackage

// File: rtl/rtcsel_lock.sv
module rtcsel_lock
    import rtcsel_pkg::*;
(
    input  logic     clk,
    input  logic     bkp_rst,
    input  wr_req_t  req,
    output rtc_src_e sel_q
);

    rtc_src_e sel_r;

    always_ff @(posedge clk) begin
        if (bkp_rst) begin
            sel_r <= SRC_NONE;
        end else if (write_accepted(req, sel_r)) begin
            sel_r <= req.sel;
        end
    end

    assign sel_q = sel_r;

endmodule

// File: rtl/rtcsel_prescale.sv
module rtcsel_prescale #(
    parameter int DIV = 128
) (
    input  logic hse_clk,
    input  logic hse_rst,
    output logic div_clk
);

    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt;

    always_ff @(posedge hse_clk) begin
        if (hse_rst) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign div_clk = cnt[CW-1];

endmodule

// File: rtl/rtcsel_mux.sv
module rtcsel_mux
    import rtcsel_pkg::*;
(
    input  rtc_src_e sel,
    input  logic     lse_clk,
    input  logic     lsi_clk,
    input  logic     hdiv_clk,
    input  logic     main_pwr_off,
    output clk_out_t out
);

    logic [NUM_SRC-1:0] src_vec;
    logic [NUM_SRC-1:0] alive_vec;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            if (i == int'(SRC_NONE)) begin : g_none
                assign src_vec[i]   = 1'b0;
                assign alive_vec[i] = 1'b0;
            end else if (i == int'(SRC_XTAL)) begin : g_xtal
                assign src_vec[i]   = lse_clk;
                assign alive_vec[i] = 1'b1;
            end else if (i == int'(SRC_RC)) begin : g_rc
                assign src_vec[i]   = lsi_clk;
                assign alive_vec[i] = !main_pwr_off;
            end else begin : g_hdiv
                assign src_vec[i]   = hdiv_clk;
                assign alive_vec[i] = !main_pwr_off;
            end
        end
    endgenerate

    always_comb begin
        out.run   = src_vec[sel];
        out.valid = alive_vec[sel] &&
                    (survives_main_loss(sel) || !main_pwr_off);
    end

endmodule

// File: rtl/rtcsel_top.sv
module rtcsel_top
    import rtcsel_pkg::*;
#(
    parameter int DIV = PRESC_DIV
) (
    input  logic             clk,
    input  logic             bkp_rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_unprot,
    input  logic             hse_clk,
    input  logic             hse_rst,
    input  logic             lse_clk,
    input  logic             lsi_clk,
    input  logic             main_pwr_off,
    output logic [SEL_W-1:0] sel_q,
    output logic             rtc_clk,
    output logic             clk_valid
);

    wr_req_t  req;
    rtc_src_e sel_cur;
    logic     hdiv_clk;
    clk_out_t mux_out;

    always_comb begin
        req.en     = wr_en;
        req.unprot = wr_unprot;
        req.sel    = rtc_src_e'(wr_sel);
    end

    rtcsel_lock u_lock (
        .clk     (clk),
        .bkp_rst (bkp_rst),
        .req     (req),
        .sel_q   (sel_cur)
    );

    rtcsel_prescale #(.DIV(DIV)) u_presc (
        .hse_clk (hse_clk),
        .hse_rst (hse_rst),
        .div_clk (hdiv_clk)
    );

    rtcsel_mux u_mux (
        .sel          (sel_cur),
        .lse_clk      (lse_clk),
        .lsi_clk      (lsi_clk),
        .hdiv_clk     (hdiv_clk),
        .main_pwr_off (main_pwr_off),
        .out          (mux_out)
    );

    assign sel_q     = sel_cur;
    assign rtc_clk   = mux_out.run;
    assign clk_valid = mux_out.valid;

endmodule

// File: rtl/rtcsel_checker.sv
module rtcsel_checker (
    input logic       clk,
    input logic       bkp_rst,
    input logic       wr_unprot,
    input logic       main_pwr_off,
    input logic [1:0] sel_q,
    input logic       rtc_clk,
    input logic       clk_valid
);

    AST_RST_CLEARS: assert property (@(posedge clk) bkp_rst |=> sel_q == 2'b00); // R2

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (bkp_rst)
        (sel_q != 2'b00) |=> $stable(sel_q)); // R3

    AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (bkp_rst)
        !wr_unprot |=> $stable(sel_q)); // R4

    AST_NONE_QUIET: assert property (@(posedge clk) disable iff (bkp_rst)
        (sel_q == 2'b00) |-> (!rtc_clk && !clk_valid)); // R6

    AST_PWR_INVALID: assert property (@(posedge clk) disable iff (bkp_rst)
        (main_pwr_off && sel_q != 2'b01) |-> !clk_valid); // R7

    AST_XTAL_VALID: assert property (@(posedge clk) disable iff (bkp_rst)
        (sel_q == 2'b01) |-> clk_valid); // R7

endmodule

bind rtcsel_top rtcsel_checker u_chk (
    .clk          (clk),
    .bkp_rst      (bkp_rst),
    .wr_unprot    (wr_unprot),
    .main_pwr_off (main_pwr_off),
    .sel_q        (sel_q),
    .rtc_clk      (rtc_clk),
    .clk_valid    (clk_valid)
);

// File: tb/rtcsel_top_bench.sv
`timescale 1ns/1ps
module rtcsel_top_bench;

    logic       clk = 1'b0;
    logic       bkp_rst = 1'b1;
    logic       hse_rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'b00;
    logic       wr_unprot = 1'b0;
    logic       lse_clk = 1'b0;
    logic       lsi_clk = 1'b0;
    logic       main_pwr_off = 1'b0;
    logic [1:0] sel_q;
    logic       rtc_clk;
    logic       clk_valid;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int gcnt = 0;
    bit done = 0;
    string cur_req = "R2";

    int m_sel = 0;
    int m_hcnt = 0;

    always #10 clk = ~clk;

    rtcsel_top u_rtcsel_top (
        .clk(clk), .bkp_rst(bkp_rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_unprot(wr_unprot), .hse_clk(clk), .hse_rst(hse_rst),
        .lse_clk(lse_clk), .lsi_clk(lsi_clk), .main_pwr_off(main_pwr_off),
        .sel_q(sel_q), .rtc_clk(rtc_clk), .clk_valid(clk_valid)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (bkp_rst) m_sel = 0;
        else if (wr_en && wr_unprot && m_sel == 0) m_sel = int'(wr_sel);
        if (hse_rst) m_hcnt = 0;
        else m_hcnt = (m_hcnt + 1) % 128;
        gcnt <= gcnt + 1;
        lse_clk <= ((gcnt + 1) % 6) >= 3;
        lsi_clk <= ((gcnt + 1) % 4) >= 2;
    end

    function automatic logic exp_rtc();
        case (m_sel)
            1: return lse_clk;
            2: return lsi_clk;
            3: return (m_hcnt >= 64);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_valid();
        if (m_sel == 0) return 1'b0;
        if (m_sel == 1) return 1'b1;
        return !main_pwr_off;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #5;
        if (!done) begin
            chk(int'(sel_q) == m_sel, cur_req, int'(sel_q), m_sel);
            chk(rtc_clk == exp_rtc(), cur_req, int'(rtc_clk), int'(exp_rtc()));
            chk(clk_valid == exp_valid(), cur_req, int'(clk_valid), int'(exp_valid()));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] s, input logic unp);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_unprot = unp;
        @(negedge clk);
        wr_en = 1'b0; wr_unprot = 1'b0;
    endtask

    task automatic backup_reset();
        @(negedge clk); bkp_rst = 1'b1;
        @(negedge clk); bkp_rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R2";
        chk(sel_q == 2'b00, "R2", int'(sel_q), 0);
        chk(!rtc_clk && !clk_valid, "R6", int'(rtc_clk), 0);
        bkp_rst = 1'b0; hse_rst = 1'b0;

        cur_req = "R4";
        wr(2'b01, 1'b0);
        chk(sel_q == 2'b00, "R4", int'(sel_q), 0);

        cur_req = "R8";
        wr(2'b00, 1'b1);
        chk(sel_q == 2'b00, "R8", int'(sel_q), 0);
        cur_req = "R6";
        repeat (5) @(negedge clk);
        chk(!clk_valid, "R6", int'(clk_valid), 0);

        cur_req = "R9";
        wr(2'b10, 1'b1);
        chk(sel_q == 2'b10, "R9", int'(sel_q), 2);
        cur_req = "R1";
        repeat (12) @(negedge clk);
        chk(clk_valid, "R7", int'(clk_valid), 1);

        cur_req = "R7";
        main_pwr_off = 1'b1;
        @(negedge clk);
        chk(!clk_valid, "R7", int'(clk_valid), 0);
        main_pwr_off = 1'b0;

        cur_req = "R3";
        wr(2'b01, 1'b1);
        wr(2'b11, 1'b1);
        chk(sel_q == 2'b10, "R3", int'(sel_q), 2);

        cur_req = "R2";
        backup_reset();
        chk(sel_q == 2'b00, "R2", int'(sel_q), 0);

        cur_req = "R1";
        wr(2'b01, 1'b1);
        chk(sel_q == 2'b01, "R1", int'(sel_q), 1);
        repeat (12) @(negedge clk);
        cur_req = "R7";
        main_pwr_off = 1'b1;
        repeat (4) @(negedge clk);
        chk(clk_valid, "R7", int'(clk_valid), 1);
        main_pwr_off = 1'b0;

        cur_req = "R2";
        backup_reset();
        cur_req = "R5";
        @(negedge clk); hse_rst = 1'b1;
        @(negedge clk); hse_rst = 1'b0;
        wr(2'b11, 1'b1);
        chk(sel_q == 2'b11, "R1", int'(sel_q), 3);
        repeat (300) @(negedge clk);
        main_pwr_off = 1'b1;
        @(negedge clk);
        chk(!clk_valid, "R7", int'(clk_valid), 0);
        main_pwr_off = 1'b0;
        wr(2'b01, 1'b1);
        chk(sel_q == 2'b11, "R3", int'(sel_q), 3);
        repeat (5) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule